// File: doc/BRIEF.md
# Single-Cycle Instruction Decoder and Next-PC Selector

This purely combinational block turns one 32-bit instruction word into the full set of steering signals for a single-cycle load/store processor core. It covers register-to-register arithmetic and logic (add, sub, and, or, slt), word load and store, branch-if-equal and the absolute jump. It does not hold the register file, the memories or the ALU. The surrounding core feeds it the instruction, the ALU's equality flag and the current PC. It returns the register numbers, the sign-extended immediate, the control strobes, the ALU operation code and the address of the next instruction.

The ALU code comes from two levels of decode. The opcode first picks a 2-bit ALU class. That class then passes straight through to add or subtract, or, for register-format instructions, hands the choice to the funct field. The next PC is chosen from three candidates in a fixed order of priority: jump target, taken-branch target, sequential.

Top module: `sc_decode_npc`

## Requirements
- R1: `rs_num` equals instruction bits 25:21, `rt_num` bits 20:16, `rd_num` bits 15:11, `shamt` bits 10:6 and `funct` bits 5:0, for every instruction word.
- R2: `imm_ext` is instruction bits 15:0 with bit 15 copied into all 16 upper bits.
- R3: Opcode 0 with a supported funct gives reg_dst=1, alu_src=0, mem_to_reg=0, reg_wr=1, mem_rd=0, mem_wr=0, branch=0, jump=0, alu_op=2'b10.
- R4: Opcode 35 (load) gives reg_dst=0, alu_src=1, mem_to_reg=1, reg_wr=1, mem_rd=1, mem_wr=0, branch=0, jump=0, alu_op=2'b00.
- R5: Opcode 43 (store) gives alu_src=1, mem_wr=1, alu_op=2'b00, and every other strobe is 0. The don't-care selects reg_dst and mem_to_reg are driven 0.
- R6: Opcode 4 (branch-if-equal) gives branch=1, alu_op=2'b01, and every other strobe is 0.
- R7: With alu_op=2'b10, funct 6'h20 gives alu_ctl 4'b0010, 6'h22 gives 4'b0110, 6'h24 gives 4'b0000, 6'h25 gives 4'b0001 and 6'h2A gives 4'b0111.
- R8: alu_op=2'b00 gives alu_ctl 4'b0010 and alu_op=2'b01 gives 4'b0110, whatever the funct field holds.
- R9: When neither jump nor a taken branch applies, pc_next = pc + 4, wrapping modulo 2^32.
- R10: With branch=1 and zero=1, pc_next = pc + 4 + (imm_ext << 2). With branch=1 and zero=0, pc_next = pc + 4.
- R11: Opcode 2 (jump) gives jump=1 and every other strobe 0, with alu_op=2'b00. pc_next = {(pc+4)[31:28], instr[25:0], 2'b00}, whatever zero holds.
- R12: Any opcode outside {0, 2, 4, 35, 43} drives every strobe to 0 and alu_op to 2'b00, and pc_next = pc + 4 even when zero=1. Opcode 0 with a funct outside the R7 set keeps the R3 vector except that reg_wr=0, and gives alu_ctl 4'b0010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word being executed |
| zero | input | 1 | ALU result-is-zero flag |
| pc | input | 32 | Address of the current instruction |
| rs_num | output | 5 | First source register number |
| rt_num | output | 5 | Second source / load destination register number |
| rd_num | output | 5 | Register-format destination number |
| shamt | output | 5 | Shift-amount field |
| funct | output | 6 | Function field |
| imm_ext | output | 32 | Sign-extended 16-bit immediate |
| reg_dst | output | 1 | Write register comes from rd_num (1) or rt_num (0) |
| alu_src | output | 1 | Second ALU operand is imm_ext (1) or the register (0) |
| mem_to_reg | output | 1 | Register write data comes from memory (1) or the ALU (0) |
| reg_wr | output | 1 | Register file write enable |
| mem_rd | output | 1 | Data memory read enable |
| mem_wr | output | 1 | Data memory write enable |
| branch | output | 1 | Conditional branch instruction |
| jump | output | 1 | Jump instruction |
| alu_op | output | 2 | First-level ALU class |
| alu_ctl | output | 4 | Operation code for the ALU |
| pc_next | output | 32 | Address of the next instruction |

## Verification
The block holds no state, so any fault in its decode shows at the ports in the same evaluation as the instruction that provokes it. There is no delay and no history to wait through. A wrongly decoded opcode shows up as a bad strobe vector or a wrong `pc_next` on that very instruction word. A fault in the second-level decode appears only in `alu_ctl`, and only for register-format words with the affected funct. The bench therefore draws random words that cover every opcode class, every supported funct and unsupported values, together with random PCs and zero flags. It adds directed cases for backward branches, PC wrap-around and jumps from high PCs.

// File: rtl/sc_decode_npc.sv
module sc_decode_npc #(
  parameter int XLEN = 32,
  parameter int RNW  = 5
) (
  input  logic [31:0]     instr,
  input  logic            zero,
  input  logic [XLEN-1:0] pc,
  output logic [RNW-1:0]  rs_num,
  output logic [RNW-1:0]  rt_num,
  output logic [RNW-1:0]  rd_num,
  output logic [4:0]      shamt,
  output logic [5:0]      funct,
  output logic [XLEN-1:0] imm_ext,
  output logic            reg_dst,
  output logic            alu_src,
  output logic            mem_to_reg,
  output logic            reg_wr,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            branch,
  output logic            jump,
  output logic [1:0]      alu_op,
  output logic [3:0]      alu_ctl,
  output logic [XLEN-1:0] pc_next
);
  localparam logic [5:0] OP_REG  = 6'd0;
  localparam logic [5:0] OP_JMP  = 6'd2;
  localparam logic [5:0] OP_BEQ  = 6'd4;
  localparam logic [5:0] OP_LOAD = 6'd35;
  localparam logic [5:0] OP_STOR = 6'd43;

  localparam logic [3:0] ALU_AND = 4'b0000;
  localparam logic [3:0] ALU_OR  = 4'b0001;
  localparam logic [3:0] ALU_ADD = 4'b0010;
  localparam logic [3:0] ALU_SUB = 4'b0110;
  localparam logic [3:0] ALU_SLT = 4'b0111;

  localparam int JHI = XLEN - 28;

  logic [5:0]      opcode;
  logic [XLEN-1:0] pc_seq, br_tgt, jmp_tgt;
  logic            funct_ok;

  assign opcode  = instr[31:26];
  assign rs_num  = instr[25:21];
  assign rt_num  = instr[20:16];
  assign rd_num  = instr[15:11];
  assign shamt   = instr[10:6];
  assign funct   = instr[5:0];
  assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};

  assign pc_seq  = pc + XLEN'(4);
  assign br_tgt  = pc_seq + (imm_ext << 2);
  assign jmp_tgt = {pc_seq[XLEN-1 -: JHI], instr[25:0], 2'b00};

  always_comb begin
    reg_dst    = 1'b0;
    alu_src    = 1'b0;
    mem_to_reg = 1'b0;
    reg_wr     = 1'b0;
    mem_rd     = 1'b0;
    mem_wr     = 1'b0;
    branch     = 1'b0;
    jump       = 1'b0;
    alu_op     = 2'b00;
    case (opcode)
      OP_REG: begin
        reg_dst = 1'b1;
        reg_wr  = 1'b1;
        alu_op  = 2'b10;
      end
      OP_LOAD: begin
        alu_src    = 1'b1;
        mem_to_reg = 1'b1;
        reg_wr     = 1'b1;
        mem_rd     = 1'b1;
      end
      OP_STOR: begin
        alu_src = 1'b1;
        mem_wr  = 1'b1;
      end
      OP_BEQ: begin
        branch = 1'b1;
        alu_op = 2'b01;
      end
      OP_JMP:  jump = 1'b1;
      default: ;
    endcase

    funct_ok = 1'b1;
    case (alu_op)
      2'b01:   alu_ctl = ALU_SUB;
      2'b10: begin
        case (funct)
          6'h20:   alu_ctl = ALU_ADD;
          6'h22:   alu_ctl = ALU_SUB;
          6'h24:   alu_ctl = ALU_AND;
          6'h25:   alu_ctl = ALU_OR;
          6'h2A:   alu_ctl = ALU_SLT;
          default: begin
            alu_ctl  = ALU_ADD;
            funct_ok = 1'b0;
          end
        endcase
      end
      default: alu_ctl = ALU_ADD;
    endcase
    if (!funct_ok) reg_wr = 1'b0;

    if (jump)                pc_next = jmp_tgt;
    else if (branch && zero) pc_next = br_tgt;
    else                     pc_next = pc_seq;

    if (!$isunknown({instr, zero, pc})) begin
      // R4 R5
      mem_excl_chk: assert (!(mem_rd && mem_wr));
      // R11
      jump_quiet_chk: assert (!jump || (!reg_wr && !mem_wr && !mem_rd && !branch));
      // R4
      load_src_chk: assert (!mem_to_reg || (mem_rd && reg_wr));
      // R6
      branch_sub_chk: assert (!branch || alu_ctl == ALU_SUB);
      // R12
      unknown_op_chk: assert ((opcode inside {OP_REG, OP_JMP, OP_BEQ, OP_LOAD, OP_STOR})
                              || (!reg_wr && !mem_wr && !mem_rd && pc_next == pc + XLEN'(4)));
      // R3
      reg_dst_chk: assert (!reg_dst || alu_op == 2'b10);
    end
  end
endmodule

// File: tb/sc_decode_npc_bench.sv
module sc_decode_npc_bench;
  logic        clk = 1'b0;
  logic [31:0] instr = '0;
  logic        zero = 1'b0;
  logic [31:0] pc = '0;
  logic [4:0]  rs_num, rt_num, rd_num, shamt;
  logic [5:0]  funct;
  logic [31:0] imm_ext, pc_next;
  logic        reg_dst, alu_src, mem_to_reg, reg_wr, mem_rd, mem_wr, branch, jump;
  logic [1:0]  alu_op;
  logic [3:0]  alu_ctl;
  int          n_tests = 0;
  int          n_fail  = 0;
  bit          done    = 1'b0;

  always #10 clk = ~clk;

  sc_decode_npc u_sc_decode_npc (
    .instr(instr), .zero(zero), .pc(pc),
    .rs_num(rs_num), .rt_num(rt_num), .rd_num(rd_num), .shamt(shamt), .funct(funct),
    .imm_ext(imm_ext), .reg_dst(reg_dst), .alu_src(alu_src), .mem_to_reg(mem_to_reg),
    .reg_wr(reg_wr), .mem_rd(mem_rd), .mem_wr(mem_wr), .branch(branch), .jump(jump),
    .alu_op(alu_op), .alu_ctl(alu_ctl), .pc_next(pc_next)
  );

  function automatic bit fn_known(input logic [5:0] f);
    return f inside {6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
  endfunction

  // {reg_dst, alu_src, mem_to_reg, reg_wr, mem_rd, mem_wr, branch, jump, alu_op}
  function automatic logic [9:0] exp_ctrl(input logic [31:0] w);
    case (w[31:26])
      6'd0:    return {3'b100, fn_known(w[5:0]), 4'b0000, 2'b10};
      6'd35:   return 10'b0111100000;
      6'd43:   return 10'b0100010000;
      6'd4:    return 10'b0000001001;
      6'd2:    return 10'b0000000100;
      default: return 10'b0000000000;
    endcase
  endfunction

  function automatic string ctrl_tag(input logic [31:0] w);
    case (w[31:26])
      6'd0:    return fn_known(w[5:0]) ? "R3" : "R12";
      6'd35:   return "R4";
      6'd43:   return "R5";
      6'd4:    return "R6";
      6'd2:    return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [3:0] exp_alu(input logic [31:0] w);
    case (w[31:26])
      6'd0: case (w[5:0])
        6'h22:   return 4'b0110;
        6'h24:   return 4'b0000;
        6'h25:   return 4'b0001;
        6'h2A:   return 4'b0111;
        default: return 4'b0010;
      endcase
      6'd4:    return 4'b0110;
      default: return 4'b0010;
    endcase
  endfunction

  function automatic logic [31:0] exp_npc(input logic [31:0] w, input logic z, input logic [31:0] p);
    logic [31:0] s;
    s = p + 32'd4;
    if (w[31:26] == 6'd2) return {s[31:28], w[25:0], 2'b00};
    if (w[31:26] == 6'd4 && z) return s + {{14{w[15]}}, w[15:0], 2'b00};
    return s;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic z, input logic [31:0] p);
    string t;
    @(posedge clk);
    instr = w; zero = z; pc = p;
    @(negedge clk);
    chk("R1", {7'd0, rs_num, rt_num, rd_num, shamt, funct}, {7'd0, w[25:0]});
    chk("R2", imm_ext, {{16{w[15]}}, w[15:0]});
    chk(ctrl_tag(w), {22'd0, reg_dst, alu_src, mem_to_reg, reg_wr, mem_rd, mem_wr,
                      branch, jump, alu_op}, {22'd0, exp_ctrl(w)});
    t = (w[31:26] == 6'd0) ? "R7" : "R8";
    chk(t, {28'd0, alu_ctl}, {28'd0, exp_alu(w)});
    if (w[31:26] == 6'd2)      t = "R11";
    else if (w[31:26] == 6'd4) t = "R10";
    else if (w[31:26] inside {6'd0, 6'd35, 6'd43}) t = "R9";
    else                       t = "R12";
    chk(t, pc_next, exp_npc(w, z, p));
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [25:0] rest);
    return {op, rest};
  endfunction

  initial begin
    logic [5:0] ops [6];
    logic [5:0] fns [6];
    ops = '{6'd0, 6'd2, 6'd4, 6'd35, 6'd43, 6'd63};
    fns = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A, 6'h21};
    process::self().srandom(32'd7);
    // R7 every funct, R8 funct ignored on load/store/branch
    for (int i = 0; i < 6; i++) apply(mk(6'd0, {5'd3, 5'd4, 5'd5, 5'd0, fns[i]}), 1'b0, 32'h100);
    apply(mk(6'd35, 26'h00000_22), 1'b0, 32'h200);
    apply(mk(6'd43, 26'h00000_24), 1'b1, 32'h204);
    // R10 backward taken, forward not taken
    apply(mk(6'd4, {5'd1, 5'd2, 16'hFFFE}), 1'b1, 32'h1000);
    apply(mk(6'd4, {5'd1, 5'd2, 16'h0010}), 1'b0, 32'h1000);
    // R9 wrap, R11 high PC with zero set, R12 unknown with zero set
    apply(mk(6'd0, {15'd0, 5'd0, 6'h20}), 1'b0, 32'hFFFF_FFFC);
    apply(mk(6'd2, 26'h3FF_FFFF), 1'b1, 32'hAFFF_FFF8);
    apply(mk(6'd5, 26'h00000_10), 1'b1, 32'h3000);
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] op;
      logic [25:0] rest;
      op = ops[$urandom_range(0, 5)];
      if (op == 6'd63) op = 6'($urandom);
      rest = 26'($urandom);
      if (op == 6'd0 && $urandom_range(0, 3) != 0) rest[5:0] = fns[$urandom_range(0, 4)];
      apply({op, rest}, 1'($urandom), $urandom);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule